// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block sits between a processor's load/store path and a slower backing memory. The processor issues one byte-wide read or write at a time over a valid/ready handshake. The cache answers with a one-cycle response pulse. For a read, the pulse carries the addressed byte. For a write, it carries the byte that was stored. Storage is arranged as sets of two lines. Each line holds a tag, a valid flag, a modified flag and a 32-bit block. A request looks in only the one set that its address selects, and it compares both stored tags at the same time.

When a request misses, the controller picks a line to replace. It uses an empty line if the set has one. Otherwise it uses the line that was touched less recently, which it tracks with a single bit per set. If the replaced line holds modified data, the controller first writes that block back to memory. It then reads the new block in, returns the response and goes back to idle. Stores go only into the cache, so memory sees a block only when a modified line is evicted.

The address is split into a tag, a set index and a 2-bit byte offset. The set-index width is a parameter. With a 24-bit address and a 13-bit index, the tag is 9 bits. The default build uses a smaller index so that the storage stays small.

Top module: `cache2w`

## Requirements
- R1: A request address is decoded as tag = bits [ADDR_W-1:SET_W+2], set index = bits [SET_W+1:2] and byte offset = bits [1:0]. The memory block address is the request address with its two low bits removed. For a write-back, that block address is {stored tag, set index}.
- R2: A request hits when either line of the indexed set is valid and its tag matches. Both lines can be hits for different tags. At most one line in a set ever matches a given tag.
- R3: A read returns byte k of the 32-bit block, meaning bits [8k+7:8k], where k is the byte offset.
- R4: When both lines of the set are valid, a miss replaces the line that was accessed (hit or filled) less recently.
- R5: A write hit merges its byte into the cached block and marks the line modified. It causes no memory request.
- R6: A miss whose victim is valid and modified writes that whole block to memory before the refill. A miss whose victim is clean or invalid issues only the refill read.
- R7: While the indexed set holds an invalid line, a fill never displaces a valid line.
- R8: A read miss installs the block unmodified. A write miss installs the fetched block with the write byte merged in and marks it modified.
- R9: With memory acknowledging each request one cycle after it appears, the response follows acceptance by 1 cycle on a hit, 2 cycles on a clean miss and 3 cycles on a modified-victim miss.
- R10: reqReady is low from the cycle after acceptance until the response cycle has ended. Memory requests are only made while reqReady is low.
- R11: Reset invalidates every line and clears every modified flag. After reset reqReady is high, and rspValid and memReqValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Processor request present |
| reqReady | output | 1 | Cache can accept a request |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | 8 | Store byte |
| rspValid | output | 1 | One-cycle response strobe |
| rspRdata | output | 8 | Loaded byte, or the stored byte on a write |
| memReqValid | output | 1 | Memory request present |
| memReqWrite | output | 1 | 1 = block write-back, 0 = block read |
| memReqAddr | output | ADDR_W-2 | Block address |
| memWdata | output | 32 | Write-back block |
| memReady | input | 1 | Memory accepts the request; read data is valid in the same cycle |
| memRdata | input | 32 | Refill block |

## Verification
A bad tag, valid flag or LRU bit shows up at the ports on the next access to that set. It appears as a wrong latency (1, 2 or 3 cycles), as an unexpected or missing memory request, or as a wrong byte. A lost modified flag does not show when the write happens. It shows only when the line is evicted: there is no write-back, and a later re-read of that address returns stale memory data. The bench therefore runs, on every set, a sequence that ends with evictions and re-reads. It compares the write-back block against its own model of memory contents.

// File: rtl/cache2w_pkg.sv
`timescale 1ns/1ps
package cache2w_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WBACK,
    ST_REFILL,
    ST_RESP
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch request and chosen victim
    logic hitUpdate;  // apply hit: LRU, write merge, response byte
    logic fill;       // install refill block into victim line
  } dpStrobes_t;
endpackage

// File: rtl/cache2w_dp.sv
`timescale 1ns/1ps
module cache2w_dp
  import cache2w_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SET_W = 4,
  parameter int BLK_BYTES = 4,
  localparam int OFF_W = $clog2(BLK_BYTES),
  localparam int BLK_W = BLK_BYTES * 8,
  localparam int TAG_W = ADDR_W - SET_W - OFF_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic                    reqWrite,
  input  logic [7:0]              reqWdata,
  input  dpStrobes_t              stb,
  input  logic [BLK_W-1:0]        memRdata,
  output logic                    hit,
  output logic                    victimDirty,
  output logic                    wbLineDirty,
  output logic [ADDR_W-OFF_W-1:0] wbAddr,
  output logic [ADDR_W-OFF_W-1:0] fillAddr,
  output logic [BLK_W-1:0]        wbData,
  output logic [7:0]              rspRdata
);
  localparam int SETS = 1 << SET_W;

  logic [TAG_W-1:0] tagMem  [2][SETS];
  logic [BLK_W-1:0] dataMem [2][SETS];
  logic [SETS-1:0]  validV  [2];
  logic [SETS-1:0]  dirtyV  [2];
  logic [SETS-1:0]  lruV;   // way to replace next when both valid

  logic [TAG_W-1:0] reqTag;
  logic [SET_W-1:0] reqIdx;
  logic [OFF_W-1:0] reqOff;
  assign reqTag = reqAddr[ADDR_W-1 -: TAG_W];
  assign reqIdx = reqAddr[OFF_W +: SET_W];
  assign reqOff = reqAddr[OFF_W-1:0];

  logic             lWrite;
  logic [TAG_W-1:0] lTag;
  logic [SET_W-1:0] lIdx;
  logic [OFF_W-1:0] lOff;
  logic [7:0]       lWdata;
  logic             lVictim;

  function automatic logic [BLK_W-1:0] mergeByte(input logic [BLK_W-1:0] blk,
                                                 input logic [OFF_W-1:0] off,
                                                 input logic [7:0] b);
    logic [BLK_W-1:0] r;
    r = blk;
    r[off*8 +: 8] = b;
    return r;
  endfunction

  // parallel tag compare, one comparator per way
  logic [1:0] hitWay;
  genvar w;
  generate
    for (w = 0; w < 2; w++) begin : gCmp
      assign hitWay[w] = validV[w][reqIdx] && (tagMem[w][reqIdx] == reqTag);
    end
  endgenerate
  assign hit = |hitWay;

  logic hitSel;
  assign hitSel = hitWay[1];

  logic curVictim;
  always_comb begin
    if (!validV[0][reqIdx])      curVictim = 1'b0;
    else if (!validV[1][reqIdx]) curVictim = 1'b1;
    else                         curVictim = lruV[reqIdx];
  end
  assign victimDirty = validV[curVictim][reqIdx] && dirtyV[curVictim][reqIdx];
  assign wbLineDirty = validV[lVictim][lIdx] && dirtyV[lVictim][lIdx];

  assign wbAddr   = {tagMem[lVictim][lIdx], lIdx};
  assign wbData   = dataMem[lVictim][lIdx];
  assign fillAddr = {lTag, lIdx};

  logic [BLK_W-1:0] hitBlk;
  assign hitBlk = dataMem[hitSel][reqIdx];

  // flags with reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 2; i++) begin
        validV[i] <= '0;
        dirtyV[i] <= '0;
      end
      lruV <= '0;
    end else begin
      if (stb.hitUpdate) begin
        lruV[reqIdx] <= ~hitSel;
        if (reqWrite) dirtyV[hitSel][reqIdx] <= 1'b1;
      end
      if (stb.fill) begin
        validV[lVictim][lIdx] <= 1'b1;
        dirtyV[lVictim][lIdx] <= lWrite;
        lruV[lIdx]            <= ~lVictim;
      end
    end
  end

  // storage and request latch, no reset needed
  always_ff @(posedge clk) begin
    if (stb.capture) begin
      lWrite  <= reqWrite;
      lTag    <= reqTag;
      lIdx    <= reqIdx;
      lOff    <= reqOff;
      lWdata  <= reqWdata;
      lVictim <= curVictim;
    end
    if (stb.hitUpdate) begin
      if (reqWrite) dataMem[hitSel][reqIdx] <= mergeByte(hitBlk, reqOff, reqWdata);
      rspRdata <= reqWrite ? reqWdata : hitBlk[reqOff*8 +: 8];
    end
    if (stb.fill) begin
      tagMem[lVictim][lIdx]  <= lTag;
      dataMem[lVictim][lIdx] <= lWrite ? mergeByte(memRdata, lOff, lWdata) : memRdata;
      rspRdata <= lWrite ? lWdata : memRdata[lOff*8 +: 8];
    end
  end

  assert_single_hit_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitWay));

  assert_write_marks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.hitUpdate && reqWrite) |=> dirtyV[$past(hitSel)][$past(reqIdx)]);

  assert_fill_flags_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.fill |=> (validV[$past(lVictim)][$past(lIdx)]
                  && dirtyV[$past(lVictim)][$past(lIdx)] == $past(lWrite)));
endmodule

// File: rtl/cache2w_ctrl.sv
`timescale 1ns/1ps
module cache2w_ctrl
  import cache2w_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       hit,
  input  logic       victimDirty,
  input  logic       memReady,
  output logic       reqReady,
  output logic       rspValid,
  output logic       memReqValid,
  output logic       memReqWrite,
  output dpStrobes_t stb
);
  ctrlState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    stb         = '0;
    reqReady    = 1'b0;
    rspValid    = 1'b0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.capture = 1'b1;
          if (hit) begin
            stb.hitUpdate = 1'b1;
            nextState     = ST_RESP;
          end else begin
            nextState = victimDirty ? ST_WBACK : ST_REFILL;
          end
        end
      end
      ST_WBACK: begin
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memReady) nextState = ST_REFILL;
      end
      ST_REFILL: begin
        memReqValid = 1'b1;
        if (memReady) begin
          stb.fill  = 1'b1;
          nextState = ST_RESP;
        end
      end
      ST_RESP: begin
        rspValid  = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assert_ready_after_rsp_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> reqReady);

  assert_no_rsp_while_ready_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !rspValid);
endmodule

// File: rtl/cache2w.sv
`timescale 1ns/1ps
module cache2w
  import cache2w_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SET_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqWdata,
  output logic              rspValid,
  output logic [7:0]        rspRdata,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [ADDR_W-3:0] memReqAddr,
  output logic [31:0]       memWdata,
  input  logic              memReady,
  input  logic [31:0]       memRdata
);
  dpStrobes_t stb;
  logic hit, victimDirty, wbLineDirty;
  logic [ADDR_W-3:0] wbAddr, fillAddr;

  cache2w_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .hit(hit),
    .victimDirty(victimDirty), .memReady(memReady), .reqReady(reqReady),
    .rspValid(rspValid), .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .stb(stb)
  );

  cache2w_dp #(.ADDR_W(ADDR_W), .SET_W(SET_W), .BLK_BYTES(4)) uDp (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .stb(stb), .memRdata(memRdata), .hit(hit),
    .victimDirty(victimDirty), .wbLineDirty(wbLineDirty), .wbAddr(wbAddr),
    .fillAddr(fillAddr), .wbData(memWdata), .rspRdata(rspRdata)
  );

  assign memReqAddr = memReqWrite ? wbAddr : fillAddr;

  assert_mem_only_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);

  assert_wb_only_dirty_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |-> wbLineDirty);
endmodule

// File: tb/sim_cache2w.sv
`timescale 1ns/1ps
module sim_cache2w;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;
  localparam int SET_W = 4;
  localparam int SETS = 1 << SET_W;
  localparam int TAG_W = ADDR_W - SET_W - 2;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0, memReady = 0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic [31:0] memRdata = '0;
  logic reqReady, rspValid, memReqValid, memReqWrite;
  logic [7:0] rspRdata;
  logic [ADDR_W-3:0] memReqAddr;
  logic [31:0] memWdata;

  cache2w #(.ADDR_W(ADDR_W), .SET_W(SET_W)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;
  int wbCount = 0, rdCount = 0;
  int lastWbAddr = 0;
  logic [31:0] lastWbData = '0;
  logic [31:0] memStore [int];
  logic [7:0] golden [int];

  function automatic logic [31:0] patBlock(int blk);
    return (blk * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [7:0] expByte(int addr);
    logic [31:0] b;
    if (golden.exists(addr)) return golden[addr];
    b = memStore.exists(addr >> 2) ? memStore[addr >> 2] : patBlock(addr >> 2);
    return b[(addr & 3)*8 +: 8];
  endfunction

  function automatic logic [31:0] expBlock(int blk);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[k*8 +: 8] = expByte(blk*4 + k);
    return r;
  endfunction

  // backing memory: acknowledges one cycle after request appears
  always @(negedge clk) begin
    if (memReqValid) begin
      memReady = 1;
      if (memReqWrite) begin
        wbCount++;
        lastWbAddr = int'(memReqAddr);
        lastWbData = memWdata;
        memStore[int'(memReqAddr)] = memWdata;
      end else begin
        rdCount++;
        memRdata = memStore.exists(int'(memReqAddr)) ? memStore[int'(memReqAddr)]
                                                     : patBlock(int'(memReqAddr));
      end
    end else begin
      memReady = 0;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int mkAddr(int tag, int set, int off);
    return ((tag & ((1 << TAG_W) - 1)) << (SET_W + 2)) | (set << 2) | off;
  endfunction

  // one access; returns response byte, latency, memory traffic
  task automatic access(bit wr, int addr, logic [7:0] wd, output logic [7:0] rd,
                        output int lat, output int wbs, output int rds);
    int wb0, rd0;
    bit readyBad;
    wb0 = wbCount; rd0 = rdCount; readyBad = 0;
    @(negedge clk);
    check(reqReady, "R10", "ready before request", reqReady, 1);
    reqValid = 1; reqWrite = wr; reqAddr = addr[ADDR_W-1:0]; reqWdata = wd;
    @(posedge clk);
    #1 reqValid = 0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (!rspValid && reqReady) readyBad = 1;
    end while (!rspValid && lat < 20);
    check(!readyBad, "R10", "ready high during miss", readyBad, 0);
    rd = rspRdata;
    wbs = wbCount - wb0; rds = rdCount - rd0;
    if (wr) golden[addr] = wd;
  endtask

  task automatic expectAcc(string req, bit wr, int addr, logic [7:0] wd,
                           int expLat, int expWb, int expRd);
    logic [7:0] rd, e;
    int lat, wbs, rds;
    e = wr ? wd : expByte(addr);
    access(wr, addr, wd, rd, lat, wbs, rds);
    check(rd == e, req, "response byte", rd, e);
    check(lat == expLat, req, "latency", lat, expLat);
    check(wbs == expWb, req, "write-backs", wbs, expWb);
    check(rds == expRd, req, "refill reads", rds, expRd);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset outputs
    check(reqReady, "R11", "reqReady in reset", reqReady, 1);
    check(!rspValid, "R11", "rspValid in reset", rspValid, 0);
    check(!memReqValid, "R11", "memReqValid in reset", memReqValid, 0);
    rstN = 1;

    for (int s = 0; s < SETS; s++) begin
      int tA, tB, tC, tE;
      tA = 100 + s; tB = 200 + s; tC = 300 + s; tE = 400 + s;
      // R6/R9/R1: cold read miss, no write-back
      expectAcc("R9", 0, mkAddr(tA, s, 0), 0, 2, 0, 1);
      // R3/R2: every byte lane hits
      for (int k = 1; k < 4; k++) expectAcc("R3", 0, mkAddr(tA, s, k), 0, 1, 0, 0);
      // R5: write hit, no memory traffic
      expectAcc("R5", 1, mkAddr(tA, s, 2), 8'(s*7 + 3), 1, 0, 0);
      // R7: second tag takes the empty line
      expectAcc("R7", 0, mkAddr(tB, s, 1), 0, 2, 0, 1);
      expectAcc("R7", 0, mkAddr(tA, s, 2), 0, 1, 0, 0); // still resident, B now LRU
      // R4: C evicts clean B
      expectAcc("R4", 0, mkAddr(tC, s, 3), 0, 2, 0, 1);
      // R6/R4: B evicts modified A, write-back first
      expectAcc("R6", 0, mkAddr(tB, s, 0), 0, 3, 1, 1);
      check(lastWbAddr == ((tA << SET_W) | s) % (1 << (ADDR_W-2)), "R1",
            "write-back address", lastWbAddr, (tA << SET_W) | s);
      check(lastWbData == expBlock(mkAddr(tA, s, 0) >> 2), "R6",
            "write-back block", lastWbData, expBlock(mkAddr(tA, s, 0) >> 2));
      // R8: write miss merges (victim C is clean)
      expectAcc("R8", 1, mkAddr(tE, s, 1), 8'(s + 8'h40), 2, 0, 1);
      expectAcc("R8", 0, mkAddr(tE, s, 1), 0, 1, 0, 0);
      expectAcc("R8", 0, mkAddr(tE, s, 0), 0, 1, 0, 0);
      // R6: A re-read from memory (victim B clean) holds the written byte
      expectAcc("R6", 0, mkAddr(tA, s, 2), 0, 2, 0, 1);
      // R8: E is modified from write miss, evicted with merged byte
      expectAcc("R8", 0, mkAddr(tC, s, 3), 0, 3, 1, 1);
      check(lastWbData == expBlock(mkAddr(tE, s, 0) >> 2), "R8",
            "write-miss block written back", lastWbData, expBlock(mkAddr(tE, s, 0) >> 2));
    end

    // R11: reset mid-run discards lines, including modified ones
    begin
      int tA;
      tA = 100;
      expectAcc("R5", 1, mkAddr(tA, 0, 1), 8'h99, 1, 0, 0);
      @(negedge clk);
      rstN = 0;
      @(negedge clk);
      rstN = 1;
      golden.delete(mkAddr(tA, 0, 1));
      expectAcc("R11", 0, mkAddr(tA, 0, 1), 0, 2, 0, 1);
    end

    finishRun();
  end
endmodule